// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block is the watchdog section of a real-time-clock companion device. A processor reaches it through a small byte-wide register port. Two reload bytes together hold a 16-bit period, counted in pulses on a tick input. Writing either reload byte restarts the countdown from the full period. When the count runs out, the block records a sticky timeout flag. It then reloads itself and keeps counting.

Two control bits choose what else a timeout does:
- With the enable bit clear, only the flag is recorded.
- With the enable bit set and the steering bit clear, the block also sets an interrupt flag and pulls an active-low interrupt line. Reading the flag register clears the interrupt flag and releases the line.
- With both bits set, the block emits an active-low reset pulse of a fixed number of system clocks. At the end of the pulse it clears its own enable bit, so it fires only once.

A reload value of zero stops the countdown. Reset clears both control bits and both flags. The reload bytes are not reset and must be written by software.

Register map, 2-bit address:
- 0: flags. Bit 0 is the timeout flag and bit 1 is the interrupt flag.
- 1: control. Bit 0 is enable and bit 1 is steering.
- 2: reload low byte.
- 3: reload high byte.

Read data appears on the clock after the read strobe.

Top module: `wdog_dual_mode`

## Requirements
- R1: Every timeout sets the timeout flag (flags bit 0), whatever the mode. The flag stays set until software writes address 0 with bit 0 = 1.
- R2: With enable=1 and steering=0, a timeout sets the interrupt flag (flags bit 1), and irq_no is low from the clock edge that consumes the final tick.
- R3: A write to address 2 or 3 loads the counter with the 16-bit value {high, low}. After N ticks from that write, the Nth tick causes a timeout. The high byte is significant.
- R4: Reading address 0 returns the flags as they were before the read, clears the interrupt flag, and returns irq_no high on the next clock.
- R5: With enable=1 and steering=1, a timeout drives wd_rst_no low for exactly RST_CYCLES clocks. When it rises, the control register reads enable=0 with steering still 1.
- R6: A reload value of zero stops the countdown: no timeout occurs however many ticks arrive.
- R7: After reset, control and flags read 0, irq_no and wd_rst_no are high, and ticks cause no timeout until a reload byte is written.
- R8: With enable=0, a timeout sets only the timeout flag, for either steering value. irq_no and wd_rst_no stay high.
- R9: A reload write in the same cycle as the final tick takes priority: no timeout is raised, and the counter restarts from the written value.
- R10: After a timeout the counter reloads from the reload bytes. The next timeout follows another full period of ticks.
- R11: Read data is registered: bus_rdata_o holds the addressed register from the clock edge that samples bus_rd_i. Reload bytes read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous power-on reset |
| tick_i | input | 1 | One-clock time-base pulse |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_no | output | 1 | Active-low interrupt |
| wd_rst_no | output | 1 | Active-low reset pulse |

## Verification
A wrong count shows up as a timeout on the wrong tick. A timeout flag read straight after the N-1th tick exposes it, as does an interrupt edge taken right after the Nth tick. A stale interrupt flag keeps irq_no low one clock after the flag read that should have released it. A wrong pulse counter or a failed disarm shows up as a reset pulse of the wrong width. It also shows up when the control register still reads enable=1 on the first read after the pulse ends.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    REG_FLAGS  = 2'd0,
    REG_CTRL   = 2'd1,
    REG_RLD_LO = 2'd2,
    REG_RLD_HI = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    MODE_FLAG_ONLY = 2'd0,
    MODE_REPEAT    = 2'd1,
    MODE_SINGLE    = 2'd2
  } wd_mode_e;

  localparam int FLAG_WDF_BIT = 0;
  localparam int FLAG_IRQ_BIT = 1;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_STR_BIT = 1;

  function automatic wd_mode_e decode_mode(input logic en, input logic steer);
    if (!en)   return MODE_FLAG_ONLY;
    if (steer) return MODE_SINGLE;
    return MODE_REPEAT;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              wdf_i,
  input  logic              irqf_i,
  input  logic              rst_done_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              en_o,
  output logic              steer_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              flags_rd_o,
  output logic              wdf_clr_o
);

  logic [DATA_W-1:0] rld_lo_q, rld_hi_q;
  logic              en_q, steer_q;
  logic [DATA_W-1:0] rdata_q;
  logic              wr_lo, wr_hi, wr_ctrl;

  assign wr_lo   = bus_wr_i && (bus_addr_i == REG_RLD_LO);
  assign wr_hi   = bus_wr_i && (bus_addr_i == REG_RLD_HI);
  assign wr_ctrl = bus_wr_i && (bus_addr_i == REG_CTRL);

  // Reload bytes carry no reset: software must program them.
  always_ff @(posedge clk_i) begin
    if (wr_lo) rld_lo_q <= bus_wdata_i;
    if (wr_hi) rld_hi_q <= bus_wdata_i;
  end

  always_comb begin
    load_val_o = {rld_hi_q, rld_lo_q};
    if (wr_lo) load_val_o = {rld_hi_q, bus_wdata_i};
    if (wr_hi) load_val_o = {bus_wdata_i, rld_lo_q};
  end

  assign load_o     = wr_lo || wr_hi;
  assign reload_o   = {rld_hi_q, rld_lo_q};
  assign flags_rd_o = bus_rd_i && (bus_addr_i == REG_FLAGS);
  assign wdf_clr_o  = bus_wr_i && (bus_addr_i == REG_FLAGS) && bus_wdata_i[FLAG_WDF_BIT];

  // The end of a reset pulse disarms the enable bit, overriding a write.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      steer_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= bus_wdata_i[CTRL_EN_BIT];
        steer_q <= bus_wdata_i[CTRL_STR_BIT];
      end
      if (rst_done_i) en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (bus_rd_i) begin
      rdata_q <= '0;
      unique case (bus_addr_i)
        REG_FLAGS: begin
          rdata_q[FLAG_WDF_BIT] <= wdf_i;
          rdata_q[FLAG_IRQ_BIT] <= irqf_i;
        end
        REG_CTRL: begin
          rdata_q[CTRL_EN_BIT]  <= en_q;
          rdata_q[CTRL_STR_BIT] <= steer_q;
        end
        REG_RLD_LO: rdata_q <= rld_lo_q;
        REG_RLD_HI: rdata_q <= rld_hi_q;
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
  assign en_o        = en_q;
  assign steer_o     = steer_q;

  // R5
  disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_done_i |=> !en_q);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             timeout_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             running;

  assign running   = (cnt_q != '0);
  assign timeout_o = tick_i && (cnt_q == ONE) && !load_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i && running) begin
      cnt_q <= (cnt_q == ONE) ? reload_i : cnt_q - ONE;
    end
  end

  // R3
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !load_i) |=> !running);

  // R6
  no_idle_timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> !timeout_o);

endmodule

// File: rtl/wdog_events.sv
module wdog_events
  import wdog_pkg::*;
#(
  parameter int RST_CYCLES = 8,
  localparam int RST_W = $clog2(RST_CYCLES + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     timeout_i,
  input  wd_mode_e mode_i,
  input  logic     flags_rd_i,
  input  logic     wdf_clr_i,
  output logic     wdf_o,
  output logic     irqf_o,
  output logic     irq_no,
  output logic     wd_rst_no,
  output logic     rst_done_o
);

  localparam logic [RST_W-1:0] PULSE_LEN = RST_W'(RST_CYCLES);
  localparam logic [RST_W-1:0] PULSE_ONE = RST_W'(1);

  logic             wdf_q, irqf_q, irqf_d;
  logic             irq_n_q, wd_rst_n_q;
  logic [RST_W-1:0] pulse_cnt_q;
  logic             pulse_active;

  assign pulse_active = (pulse_cnt_q != '0);
  assign rst_done_o   = pulse_active && (pulse_cnt_q == PULSE_ONE);

  always_comb begin
    irqf_d = irqf_q;
    if (flags_rd_i) irqf_d = 1'b0;
    if (timeout_i && mode_i == MODE_REPEAT) irqf_d = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wdf_q   <= 1'b0;
      irqf_q  <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      if (timeout_i)      wdf_q <= 1'b1;
      else if (wdf_clr_i) wdf_q <= 1'b0;
      irqf_q  <= irqf_d;
      irq_n_q <= !irqf_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pulse_cnt_q <= '0;
      wd_rst_n_q  <= 1'b1;
    end else if (pulse_active) begin
      pulse_cnt_q <= pulse_cnt_q - PULSE_ONE;
      if (pulse_cnt_q == PULSE_ONE) wd_rst_n_q <= 1'b1;
    end else if (timeout_i && mode_i == MODE_SINGLE) begin
      pulse_cnt_q <= PULSE_LEN;
      wd_rst_n_q  <= 1'b0;
    end
  end

  assign wdf_o     = wdf_q;
  assign irqf_o    = irqf_q;
  assign irq_no    = irq_n_q;
  assign wd_rst_no = wd_rst_n_q;

  // R1
  wdf_on_timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> wdf_q);

  // R2
  irq_on_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_i && mode_i == MODE_REPEAT) |=> !irq_no);

  // R4
  irq_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_rd_i && !timeout_i) |=> irq_no);

  // R8
  quiet_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_i && mode_i == MODE_FLAG_ONLY && !flags_rd_i && !pulse_active)
      |=> ($stable(irq_no) && wd_rst_no));

endmodule

// File: rtl/wdog_dual_mode.sv
module wdog_dual_mode
  import wdog_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_no,
  output logic              wd_rst_no
);

  localparam int CNT_W = 2 * DATA_W;

  logic             en, steer, load, flags_rd, wdf_clr;
  logic             wdf, irqf, rst_done, timeout;
  logic [CNT_W-1:0] load_val, reload;
  wd_mode_e         mode;

  assign mode = decode_mode(en, steer);

  wdog_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .wdf_i       (wdf),
    .irqf_i      (irqf),
    .rst_done_i  (rst_done),
    .bus_rdata_o (bus_rdata_o),
    .en_o        (en),
    .steer_o     (steer),
    .load_o      (load),
    .load_val_o  (load_val),
    .reload_o    (reload),
    .flags_rd_o  (flags_rd),
    .wdf_clr_o   (wdf_clr)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .reload_i   (reload),
    .timeout_o  (timeout)
  );

  wdog_events #(.RST_CYCLES(RST_CYCLES)) u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .timeout_i  (timeout),
    .mode_i     (mode),
    .flags_rd_i (flags_rd),
    .wdf_clr_i  (wdf_clr),
    .wdf_o      (wdf),
    .irqf_o     (irqf),
    .irq_no     (irq_no),
    .wd_rst_no  (wd_rst_no),
    .rst_done_o (rst_done)
  );

  // R5
  pulse_end_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wd_rst_no) |-> !en);

  // R9
  write_beats_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !flags_rd) |=> $stable(irq_no));

endmodule

// File: tb/tb_wdog_dual_mode.sv
`timescale 1ns/1ps
module tb_wdog_dual_mode;

  localparam int DATA_W     = 8;
  localparam int RST_CYCLES = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [1:0]        bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq_n, wd_rst_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wdog_dual_mode #(.DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .bus_wr_i    (bus_wr),
    .bus_rd_i    (bus_rd),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_no      (irq_n),
    .wd_rst_no   (wd_rst_n)
  );

  // scoreboard of expected read data
  string             req_q[$];
  logic [DATA_W-1:0] exp_q[$];
  logic              rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  task automatic chk(input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        chk("R11", 8'hEE, 8'h00);
      end else begin
        chk(req_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input string req, input logic [1:0] a,
                        input logic [DATA_W-1:0] e);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    req_q.push_back(req); exp_q.push_back(e);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (!wd_rst_n && w < 100) begin
      w++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R7 reset state
    chk("R7", {7'd0, irq_n}, 8'd1);
    chk("R7", {7'd0, wd_rst_n}, 8'd1);
    rd_exp("R7", 2'd1, 8'h00);
    rd_exp("R7", 2'd0, 8'h00);
    ticks(5);
    rd_exp("R7", 2'd0, 8'h00);

    // flag-only mode, period 3
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h03);
    ticks(2);
    rd_exp("R3", 2'd0, 8'h00);
    ticks(1);
    chk("R8", {7'd0, irq_n}, 8'd1);
    chk("R8", {7'd0, wd_rst_n}, 8'd1);
    rd_exp("R1", 2'd0, 8'h01);
    rd_exp("R1", 2'd0, 8'h01);
    wr(2'd0, 8'h01);
    rd_exp("R1", 2'd0, 8'h00);
    ticks(3);
    rd_exp("R10", 2'd0, 8'h01);
    wr(2'd0, 8'h01);

    // steering set, enable clear: still flag only
    wr(2'd1, 8'h02);
    ticks(3);
    chk("R8", {7'd0, irq_n}, 8'd1);
    chk("R8", {7'd0, wd_rst_n}, 8'd1);
    rd_exp("R8", 2'd0, 8'h01);
    wr(2'd0, 8'h01);

    // repetitive interrupt mode
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h04);
    ticks(3);
    chk("R2", {7'd0, irq_n}, 8'd1);
    ticks(1);
    chk("R2", {7'd0, irq_n}, 8'd0);
    rd_exp("R4", 2'd0, 8'h03);
    chk("R4", {7'd0, irq_n}, 8'd1);
    rd_exp("R4", 2'd0, 8'h01);
    wr(2'd0, 8'h01);

    // write in the same cycle as the final tick
    wr(2'd2, 8'h04);
    ticks(3);
    @(negedge clk);
    tick = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h04;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    chk("R9", {7'd0, irq_n}, 8'd1);
    rd_exp("R9", 2'd0, 8'h00);
    ticks(3);
    chk("R9", {7'd0, irq_n}, 8'd1);
    ticks(1);
    chk("R9", {7'd0, irq_n}, 8'd0);
    rd_exp("R9", 2'd0, 8'h03);
    wr(2'd0, 8'h01);

    // zero reload stops the countdown
    wr(2'd2, 8'h00);
    ticks(20);
    chk("R6", {7'd0, irq_n}, 8'd1);
    rd_exp("R6", 2'd0, 8'h00);

    // single-shot reset pulse
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h02);
    ticks(2);
    pulse_width(w);
    chk("R5", 8'(w), 8'(RST_CYCLES));
    chk("R5", {7'd0, irq_n}, 8'd1);
    rd_exp("R5", 2'd1, 8'h02);
    rd_exp("R5", 2'd0, 8'h01);
    wr(2'd0, 8'h01);

    // 16-bit period using the high byte
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h01);
    wr(2'd2, 8'h00);
    rd_exp("R11", 2'd2, 8'h00);
    rd_exp("R11", 2'd3, 8'h01);
    ticks(255);
    rd_exp("R3", 2'd0, 8'h00);
    ticks(1);
    rd_exp("R3", 2'd0, 8'h01);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) chk("R11", 8'(exp_q.size()), 8'h00);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule